// File: doc/BRIEF.md
# Break-Aware Asynchronous Serial Receiver

This block receives asynchronous serial frames on a single line. A 16x oversampling enable pulse sets its timing. A frame is one low start bit, then 8 or 9 data bits sent least significant bit first, then one stop bit. A mode input selects the number of data bits. Each bit is resolved by a three-sample majority vote around the middle of the bit. Any sample that disagrees with the others is reported as noise. Each completed word goes into a holding register, which is cleared by a read strobe.

The receiver also recognises the break condition. A break is a frame whose start bit, all data bits and stop position are all low. On a break the receiver loads zero into the holding register and sets both the framing error flag and the register-full flag, even if an earlier word is still unread. After any frame that ends with a low stop position, the receiver waits for the line to go high again before it hunts for the next start bit. This keeps a long break from being read as extra frames.

Parity checking is chosen by a parameter: none, even or odd. When parity is enabled, the last data bit of the frame is treated as the parity bit.

Top module: `uart_brk_rx`

## Requirements
- R1: After reset, the word output reads zero, and the full, framing, noise, parity, overrun and active outputs are all low.
- R2: When `mode9_i` is 0, a frame carries 8 data bits, least significant bit first. They are stored in `word_o[7:0]`, `word_o[8]` reads 0, and `full_o` is set.
- R3: When `mode9_i` is 1, a frame carries 9 data bits stored in `word_o[8:0]`. The mode is captured when the start bit is confirmed, so a change of `mode9_i` later in the same frame has no effect on that frame.
- R4: Each bit is resolved by majority over the samples taken at oversampling ticks OSR/2-1, OSR/2 and OSR/2+1 of the bit. A frame in which any bit's three samples disagree reports `noise_o`=1, and its word is still correct.
- R5: A start bit whose majority sample at mid-bit is high is discarded. `active_o` does not rise, no word is stored, and the receiver resumes hunting.
- R6: `active_o` rises when a start bit is confirmed and falls in the cycle the stop bit is resolved.
- R7: A frame that has a low stop position and at least one high data bit sets `frame_err_o` and stores its data bits. The receiver then waits for a high line sample before it hunts again.
- R8: A break (all data bits low and a low stop position, in either mode) loads zero into the word, sets `frame_err_o` and sets `full_o`. If `full_o` was already set, `overrun_o` is also set.
- R9: A frame that is not a break and completes while `full_o` is high sets `overrun_o`. The word and the framing, noise and parity flags keep their previous values.
- R10: A one-cycle pulse on `rd_i` clears `full_o` and `overrun_o`. The framing, noise and parity flags keep describing the stored word until the next word is stored.
- R11: With even parity selected (PAR_MODE=1), `par_err_o` is set when the received data bits, parity bit included, contain an odd number of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling enable, OSR pulses per bit time |
| mode9_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rd_i | input | 1 | Holding-register read strobe |
| word_o | output | 9 | Received word |
| full_o | output | 1 | Holding register holds an unread word |
| frame_err_o | output | 1 | Stop position of the stored frame was low |
| noise_o | output | 1 | Sample disagreement in the stored frame |
| par_err_o | output | 1 | Parity mismatch in the stored frame |
| overrun_o | output | 1 | A frame arrived while the register was full |
| active_o | output | 1 | A frame is being received |

## Verification
The bench builds the block with its defaults: OSR=16, a two-stage line synchroniser and even parity. It drives one tick every four clocks. Because the synchroniser delay is shorter than one tick, the bench can flip the line for exactly one sample at mid-bit, which exercises the noise vote without changing the voted bit. Even parity makes the parity flag observable on ordinary words, and it shows that an all-zero break carries correct parity. The sequence of breaks and frames arriving while the register is full reaches the overrun rules and the break rules, both separately and together.

// File: rtl/uart_brk_rx_pkg.sv
package uart_brk_rx_pkg;

   localparam int unsigned WORD_W = 9;

   typedef enum logic [2:0] {
      RX_HUNT,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_WAIT_HIGH
   } rx_state_e;

   typedef struct packed {
      logic [WORD_W-1:0] word;
      logic              frame_err;
      logic              noise;
      logic              par_err;
      logic              brk;
   } rx_frame_t;

endpackage

// File: rtl/uart_brk_rx_sync.sv
module uart_brk_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uart_brk_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] pipe_q;

   // Line idles high, so the chain resets to ones.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
   end

   assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/uart_brk_rx_framer.sv
module uart_brk_rx_framer
   import uart_brk_rx_pkg::*;
#(
   parameter int unsigned OSR      = 16,
   parameter int unsigned PAR_MODE = 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rx_i,
   input  logic      tick_i,
   input  logic      mode9_i,
   output logic      active_o,
   output logic      vld_o,
   output rx_frame_t frame_o
);

   localparam int unsigned CW  = $clog2(OSR);
   localparam int unsigned MID = OSR / 2;
   localparam logic [CW-1:0] SMP_A = CW'(MID - 1);
   localparam logic [CW-1:0] SMP_B = CW'(MID);
   localparam logic [CW-1:0] SMP_C = CW'(MID + 1);
   localparam logic [CW-1:0] LAST  = CW'(OSR - 1);

   generate
      if (OSR < 8) begin : g_bad_osr
         $error("uart_brk_rx_framer: OSR must be at least 8");
      end
      if (PAR_MODE > 2) begin : g_bad_par
         $error("uart_brk_rx_framer: PAR_MODE must be 0, 1 or 2");
      end
   endgenerate

   rx_state_e          state_q;
   logic [CW-1:0]      cnt_q;
   logic [3:0]         bit_idx_q;
   logic [1:0]         votes_q;
   logic [WORD_W-1:0]  shreg_q;
   logic               wide_q;
   logic               nf_acc_q;
   logic               active_q;
   logic               vld_q;
   rx_frame_t          frame_q;

   logic       maj;
   logic       disagree;
   logic [3:0] last_idx;
   logic       par_bad;

   // The third sample is the live line value on the deciding tick.
   assign maj      = (votes_q[0] & votes_q[1]) | (votes_q[0] & rx_i) | (votes_q[1] & rx_i);
   assign disagree = !((votes_q[0] == votes_q[1]) && (votes_q[1] == rx_i));
   assign last_idx = wide_q ? 4'd8 : 4'd7;

   generate
      if (PAR_MODE == 0) begin : g_par_none
         assign par_bad = 1'b0;
      end else if (PAR_MODE == 1) begin : g_par_even
         assign par_bad = ^shreg_q;
      end else begin : g_par_odd
         assign par_bad = ~^shreg_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= RX_HUNT;
         cnt_q     <= '0;
         bit_idx_q <= '0;
         votes_q   <= '0;
         shreg_q   <= '0;
         wide_q    <= 1'b0;
         nf_acc_q  <= 1'b0;
         active_q  <= 1'b0;
         vld_q     <= 1'b0;
         frame_q   <= '0;
      end else begin
         vld_q <= 1'b0;
         if (tick_i) begin
            case (state_q)
               RX_HUNT: begin
                  if (!rx_i) begin
                     state_q <= RX_START;
                     cnt_q   <= CW'(1);
                  end
               end
               RX_WAIT_HIGH: begin
                  if (rx_i) state_q <= RX_HUNT;
               end
               default: begin
                  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                  if (cnt_q == SMP_A) votes_q[0] <= rx_i;
                  if (cnt_q == SMP_B) votes_q[1] <= rx_i;
                  if (cnt_q == SMP_C) begin
                     unique case (state_q)
                        RX_START: begin
                           if (maj) begin
                              state_q <= RX_HUNT;
                           end else begin
                              active_q  <= 1'b1;
                              nf_acc_q  <= disagree;
                              shreg_q   <= '0;
                              wide_q    <= mode9_i;
                              bit_idx_q <= '0;
                           end
                        end
                        RX_DATA: begin
                           shreg_q[bit_idx_q] <= maj;
                           nf_acc_q           <= nf_acc_q | disagree;
                        end
                        RX_STOP: begin
                           frame_q.word      <= shreg_q;
                           frame_q.frame_err <= !maj;
                           frame_q.noise     <= nf_acc_q | disagree;
                           frame_q.par_err   <= par_bad;
                           frame_q.brk       <= (shreg_q == '0) && !maj;
                           vld_q             <= 1'b1;
                           active_q          <= 1'b0;
                           state_q           <= maj ? RX_HUNT : RX_WAIT_HIGH;
                        end
                        default: ;
                     endcase
                  end
                  if (cnt_q == LAST) begin
                     if (state_q == RX_START) begin
                        state_q <= RX_DATA;
                     end else if (state_q == RX_DATA) begin
                        if (bit_idx_q == last_idx) state_q <= RX_STOP;
                        else                       bit_idx_q <= bit_idx_q + 1'b1;
                     end
                  end
               end
            endcase
         end
      end
   end

   assign active_o = active_q;
   assign vld_o    = vld_q;
   assign frame_o  = frame_q;

   // R6
   active_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> (!active_q && $past(active_q)));

   // R5
   active_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_q) |-> ($past(state_q) == RX_START));

   // R7
   wait_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RX_WAIT_HIGH && tick_i && !rx_i) |=> (state_q == RX_WAIT_HIGH));

endmodule

// File: rtl/uart_brk_rx_status.sv
module uart_brk_rx_status
   import uart_brk_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  rx_frame_t         frame_i,
   input  logic              rd_i,
   output logic [WORD_W-1:0] word_o,
   output logic              full_o,
   output logic              fe_o,
   output logic              nf_o,
   output logic              pe_o,
   output logic              ovr_o
);

   logic [WORD_W-1:0] word_q;
   logic full_q, fe_q, nf_q, pe_q, ovr_q;
   logic busy;

   // A read in the same cycle frees the register before the new frame lands.
   assign busy = full_q && !rd_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         full_q <= 1'b0;
         fe_q   <= 1'b0;
         nf_q   <= 1'b0;
         pe_q   <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (rd_i) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
         end
         if (vld_i) begin
            if (frame_i.brk) begin
               word_q <= '0;
               fe_q   <= 1'b1;
               nf_q   <= frame_i.noise;
               pe_q   <= frame_i.par_err;
               full_q <= 1'b1;
               if (busy) ovr_q <= 1'b1;
            end else if (busy) begin
               ovr_q <= 1'b1;
            end else begin
               word_q <= frame_i.word;
               fe_q   <= frame_i.frame_err;
               nf_q   <= frame_i.noise;
               pe_q   <= frame_i.par_err;
               full_q <= 1'b1;
            end
         end
      end
   end

   assign word_o = word_q;
   assign full_o = full_q;
   assign fe_o   = fe_q;
   assign nf_o   = nf_q;
   assign pe_o   = pe_q;
   assign ovr_o  = ovr_q;

   // R8
   brk_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && frame_i.brk) |=> (full_q && fe_q && word_q == '0));

   // R9
   ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && !frame_i.brk && full_q && !rd_i) |=> (ovr_q && $stable(word_q) && $stable(fe_q)));

   // R10
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !vld_i) |=> (!full_q && !ovr_q && $stable(fe_q) && $stable(word_q)));

endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
   import uart_brk_rx_pkg::*;
#(
   parameter int unsigned OSR         = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PAR_MODE    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic              tick_i,
   input  logic              mode9_i,
   input  logic              rd_i,
   output logic [WORD_W-1:0] word_o,
   output logic              full_o,
   output logic              frame_err_o,
   output logic              noise_o,
   output logic              par_err_o,
   output logic              overrun_o,
   output logic              active_o
);

   logic      rx_s;
   logic      frm_vld;
   rx_frame_t frm;

   uart_brk_rx_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rx_i),
      .q_o   (rx_s)
   );

   uart_brk_rx_framer #(
      .OSR      (OSR),
      .PAR_MODE (PAR_MODE)
   ) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_i     (rx_s),
      .tick_i   (tick_i),
      .mode9_i  (mode9_i),
      .active_o (active_o),
      .vld_o    (frm_vld),
      .frame_o  (frm)
   );

   uart_brk_rx_status u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_i   (frm_vld),
      .frame_i (frm),
      .rd_i    (rd_i),
      .word_o  (word_o),
      .full_o  (full_o),
      .fe_o    (frame_err_o),
      .nf_o    (noise_o),
      .pe_o    (par_err_o),
      .ovr_o   (overrun_o)
   );

endmodule

// File: tb/uart_brk_rx_bench.sv
`timescale 1ns/1ps
module uart_brk_rx_bench;

   localparam int OSR = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx = 1'b1;
   logic tick;
   logic mode9 = 1'b0;
   logic rd = 1'b0;
   logic [8:0] word;
   logic full, fe, nf, pe, ovr, active;
   logic [1:0] div;

   always #2.5 clk = ~clk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div  <= '0;
         tick <= 1'b0;
      end else begin
         div  <= div + 1'b1;
         tick <= (div == 2'd3);
      end
   end

   uart_brk_rx u_uart_brk_rx (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick), .mode9_i(mode9), .rd_i(rd),
      .word_o(word), .full_o(full), .frame_err_o(fe), .noise_o(nf), .par_err_o(pe),
      .overrun_o(ovr), .active_o(active)
   );

   typedef struct {
      logic [13:0] vec;   // {word, fe, nf, pe, ovr, full}
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int errs = 0;
   int checks = 0;
   int act_rises = 0;

   logic [8:0] m_word = '0;
   logic m_fe = 0, m_nf = 0, m_pe = 0, m_ovr = 0, m_full = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_tick();
      do @(negedge clk); while (tick !== 1'b1);
   endtask

   task automatic hold_bit(input logic v, input bit glitch);
      for (int j = 0; j < OSR; j++) begin
         rx = (glitch && j == OSR / 2) ? ~v : v;
         wait_tick();
      end
   endtask

   // Driver: update the requirement model and push the expected result.
   task automatic send_frame(input logic [8:0] data, input logic nine, input logic stop,
                             input int glitch_bit, input bit flip_mode, input string tag);
      int nb;
      logic [8:0] d;
      logic p, is_brk;
      exp_t e;
      nb = nine ? 9 : 8;
      d = nine ? data : {1'b0, data[7:0]};
      p = ^d;                                  // R11 even parity
      is_brk = (d == '0) && !stop;
      if (is_brk) begin                        // R8
         m_word = '0; m_fe = 1; m_nf = (glitch_bit >= 0); m_pe = p;
         if (m_full) m_ovr = 1;
         m_full = 1;
      end else if (m_full) begin               // R9
         m_ovr = 1;
      end else begin
         m_word = d; m_fe = !stop; m_nf = (glitch_bit >= 0); m_pe = p; m_full = 1;
      end
      e.vec = {m_word, m_fe, m_nf, m_pe, m_ovr, m_full};
      e.tag = tag;
      exp_q.push_back(e);
      mode9 = nine;
      hold_bit(1'b0, glitch_bit == 0);
      chk("R6 active high after start bit", {31'b0, active}, 32'd1);
      if (flip_mode) mode9 = ~nine;
      for (int i = 0; i < nb; i++) hold_bit(d[i], glitch_bit == i + 1);
      hold_bit(stop, glitch_bit == nb + 1);
      mode9 = nine;
      hold_bit(1'b1, 1'b0);
      hold_bit(1'b1, 1'b0);
   endtask

   task automatic do_read();
      @(negedge clk) rd = 1'b1;
      @(negedge clk) rd = 1'b0;
      m_full = 0; m_ovr = 0;
      @(negedge clk);
      chk("R10 read clears full and overrun", {30'b0, full, ovr}, 32'd0);
      chk("R10 framing flag kept after read", {31'b0, fe}, {31'b0, m_fe});
   endtask

   // Monitor: a falling active marks a completed frame; status lands one cycle later.
   initial begin
      logic last;
      exp_t e;
      last = 1'b0;
      forever begin
         @(negedge clk);
         if (!last && active) act_rises++;
         if (last && !active) begin
            @(negedge clk);
            checks++;
            if (exp_q.size() == 0) begin
               errs++;
               $display("FAIL R2 unexpected frame actual=%h expected=none",
                        {word, fe, nf, pe, ovr, full});
            end else begin
               e = exp_q.pop_front();
               if ({word, fe, nf, pe, ovr, full} !== e.vec) begin
                  errs++;
                  $display("FAIL %s actual=%h expected=%h", e.tag,
                           {word, fe, nf, pe, ovr, full}, e.vec);
               end
            end
         end
         last = active;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      int rises;
      logic full_before;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 reset state", {18'b0, word, fe, nf, pe, ovr, full}, 32'd0);
      chk("R1 reset active", {31'b0, active}, 32'd0);

      send_frame(9'h035, 0, 1, -1, 0, "R2 8-bit word");
      do_read();
      send_frame(9'h007, 0, 1, -1, 0, "R11 parity error");
      do_read();
      send_frame(9'h1C3, 1, 1, -1, 1, "R3 9-bit word with mode latched");
      do_read();
      send_frame(9'h0A5, 0, 1, 4, 0, "R4 noise on one sample");
      do_read();
      send_frame(9'h05A, 0, 0, -1, 0, "R7 framing error keeps data");
      do_read();

      // R5 false start: a low pulse shorter than the sampling point
      rises = act_rises;
      full_before = full;
      for (int j = 0; j < 4; j++) begin rx = 1'b0; wait_tick(); end
      rx = 1'b1;
      repeat (3 * OSR) wait_tick();
      chk("R5 false start leaves active low", act_rises, rises);
      chk("R5 false start stores nothing", {31'b0, full}, {31'b0, full_before});

      send_frame(9'h000, 0, 0, -1, 0, "R8 break into empty register");
      send_frame(9'h011, 0, 1, -1, 0, "R9 overrun keeps word and flags");
      send_frame(9'h000, 0, 0, -1, 0, "R8 break while full sets overrun");
      do_read();
      send_frame(9'h000, 1, 0, -1, 0, "R8 break in 9-bit mode");
      do_read();
      send_frame(9'h0F0, 0, 1, -1, 0, "R10 next stored word replaces flags");
      do_read();

      repeat (20) @(negedge clk);
      chk("R2 all expected frames seen", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule